// File: doc/BRIEF.md
# CPU-Cycle Interrupt Down Counter

This block is a cartridge-side interrupt timer that advances once per CPU cycle. Software loads a 16-bit count as two byte-wide writes: a low-byte write and a high-byte write. The high-byte write arms the counter. While armed, the counter steps down by one on each CPU cycle. When it reaches zero it raises a level interrupt request. The interrupt stays up until software acknowledges it, and the acknowledge is a write to the low byte.

A parameter selects one of two arming styles. In the default style, the high-byte write copies an enable bit from the mode register into the armed flag. On expiry the counter reloads to all ones and disarms itself, so it fires only once. In the always-arm style, every high-byte write arms the counter, and the counter keeps running after it reloads. In that style the enable bit instead decides, at the moment of expiry, whether the interrupt is raised.

Top module: `cyc_irq_timer`

## Requirements
- R1: A low-byte write replaces bits 7:0 of the count with the write data and drops `irq` on the next clock.
- R2: In the default style, a high-byte write replaces bits 15:8 of the count and sets the armed flag to the value of `mode_en` in that cycle. With `mode_en` low, the counter then never raises `irq`.
- R3: While armed, the count falls by exactly one on each clock where `cyc_en` is high. It holds its value on clocks where `cyc_en` is low.
- R4: A decrement that yields zero reloads the count to 0xFFFF and sets `irq`. In the default style it also clears the armed flag, so no further interrupt follows without a new high-byte write.
- R5: `irq` is a level output. Once set, it stays high until a low-byte write or a reset.
- R6: Reset clears `irq`, clears the count and disarms the counter.
- R7: A counter armed with a count of zero wraps to 0xFFFF on its first step and raises `irq` after 65536 enabled cycles.
- R8: When a register write falls in the same clock as an enabled step, the written byte is stored and no decrement takes place in that clock.
- R9: In the always-arm style, every high-byte write arms the counter, and the counter stays armed after it reloads. `irq` is set at expiry only when `mode_en` is high in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cyc_en | input | 1 | One-cycle strobe marking a CPU cycle |
| wr_lo | input | 1 | Write strobe for the low count byte, also acknowledges `irq` |
| wr_hi | input | 1 | Write strobe for the high count byte, also arms the counter |
| wr_data | input | 8 | Write data byte |
| mode_en | input | 1 | Interrupt enable bit taken from the mode register |
| irq | output | 1 | Level interrupt request |

## Verification
A register write and an enabled decrement can land in the same clock. The bench provokes this by rewriting the low byte partway through a countdown while `cyc_en` is held high. It then measures how many enabled cycles pass before `irq` rises: if the decrement had won that clock, or had been applied on top of the write, `irq` would come early. An acknowledge can never meet an expiry in the same clock, because the write blocks the step. The bench therefore confirms separately that an acknowledge issued after expiry leaves the default instance silent for the whole wrap, while the always-arm instance fires again at the exact cycle.

// File: rtl/cyc_irq_pkg.sv
package cyc_irq_pkg;
   typedef enum logic {
      ARM_FROM_MODE = 1'b0,
      ARM_ALWAYS    = 1'b1
   } arm_style_e;
endpackage

// File: rtl/cyc_irq_count.sv
module cyc_irq_count
   import cyc_irq_pkg::*;
#(
   parameter int         BYTE_W = 8,
   parameter int         CNT_W  = 16,
   parameter arm_style_e STYLE  = ARM_FROM_MODE
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cyc_en,
   input  logic              wr_lo,
   input  logic              wr_hi,
   input  logic [BYTE_W-1:0] wr_data,
   input  logic              mode_en,
   output logic              expire
);
   localparam int HI_LSB = BYTE_W;

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] cnt_dec;
   logic             armed_q;
   logic             arm_val;
   logic             armed_after_exp;
   logic             step;

   generate
      if (STYLE == ARM_ALWAYS) begin : g_arm_always
         assign arm_val         = 1'b1;
         assign armed_after_exp = 1'b1;
      end else begin : g_arm_mode
         assign arm_val         = mode_en;
         assign armed_after_exp = 1'b0;
      end
   endgenerate

   assign cnt_dec = cnt_q - CNT_W'(1);
   assign step    = armed_q && cyc_en && !wr_lo && !wr_hi;
   assign expire  = step && (cnt_dec == '0);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q   <= '0;
         armed_q <= 1'b0;
      end else begin
         if (wr_lo) cnt_q[BYTE_W-1:0] <= wr_data;
         if (wr_hi) begin
            cnt_q[CNT_W-1:HI_LSB] <= wr_data;
            armed_q               <= arm_val;
         end
         if (expire) begin
            cnt_q   <= '1;
            armed_q <= armed_after_exp;
         end else if (step) begin
            cnt_q <= cnt_dec;
         end
      end
   end

   AST_STEP_BY_ONE: assert property (@(posedge clk) disable iff (!rst_n)
      (armed_q && cyc_en && !wr_lo && !wr_hi && cnt_q != CNT_W'(1)) |=> cnt_q == $past(cnt_q) - CNT_W'(1)); // R3
   AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (!cyc_en && !wr_lo && !wr_hi) |=> $stable(cnt_q)); // R3
   AST_RELOAD_ONES: assert property (@(posedge clk) disable iff (!rst_n)
      expire |=> (&cnt_q)); // R4
   AST_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_lo && cyc_en) |=> cnt_q[BYTE_W-1:0] == $past(wr_data)); // R8

   generate
      if (STYLE == ARM_ALWAYS) begin : g_chk_always
         AST_ALWAYS_ARMS: assert property (@(posedge clk) disable iff (!rst_n)
            wr_hi |=> armed_q); // R9
      end else begin : g_chk_mode
         AST_ARM_FOLLOWS_MODE: assert property (@(posedge clk) disable iff (!rst_n)
            wr_hi |=> armed_q == $past(mode_en)); // R2
         AST_ONE_SHOT: assert property (@(posedge clk) disable iff (!rst_n)
            expire |=> !armed_q); // R4
      end
   endgenerate
endmodule

// File: rtl/cyc_irq_flag.sv
module cyc_irq_flag
   import cyc_irq_pkg::*;
#(
   parameter arm_style_e STYLE = ARM_FROM_MODE
) (
   input  logic clk,
   input  logic rst_n,
   input  logic expire,
   input  logic ack,
   input  logic mode_en,
   output logic irq
);
   logic gate;
   logic irq_q;

   generate
      if (STYLE == ARM_ALWAYS) begin : g_gate_mode
         assign gate = mode_en;
      end else begin : g_gate_open
         assign gate = 1'b1;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n)              irq_q <= 1'b0;
      else if (ack)            irq_q <= 1'b0;
      else if (expire && gate) irq_q <= 1'b1;
   end

   assign irq = irq_q;

   AST_ACK_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
      ack |=> !irq); // R1
   AST_LEVEL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (irq && !ack) |=> irq); // R5
   AST_FIRE_ON_EXPIRE: assert property (@(posedge clk) disable iff (!rst_n)
      (expire && gate && !ack) |=> irq); // R4
endmodule

// File: rtl/cyc_irq_timer.sv
module cyc_irq_timer
   import cyc_irq_pkg::*;
#(
   parameter int         BYTE_W = 8,
   parameter int         CNT_W  = 16,
   parameter arm_style_e STYLE  = ARM_FROM_MODE
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cyc_en,
   input  logic              wr_lo,
   input  logic              wr_hi,
   input  logic [BYTE_W-1:0] wr_data,
   input  logic              mode_en,
   output logic              irq
);
   logic expire;

   generate
      if (CNT_W != 2 * BYTE_W) begin : g_bad_width
         $error("cyc_irq_timer: CNT_W must be twice BYTE_W");
      end
   endgenerate

   cyc_irq_count #(.BYTE_W(BYTE_W), .CNT_W(CNT_W), .STYLE(STYLE)) u_count (
      .clk    (clk),
      .rst_n  (rst_n),
      .cyc_en (cyc_en),
      .wr_lo  (wr_lo),
      .wr_hi  (wr_hi),
      .wr_data(wr_data),
      .mode_en(mode_en),
      .expire (expire)
   );

   cyc_irq_flag #(.STYLE(STYLE)) u_flag (
      .clk    (clk),
      .rst_n  (rst_n),
      .expire (expire),
      .ack    (wr_lo),
      .mode_en(mode_en),
      .irq    (irq)
   );

   always_comb begin
      if (rst_n) begin
         AST_RST_QUIET: assert (!(irq && $isunknown(irq))); // R6
      end
   end
endmodule

// File: tb/cyc_irq_timer_tb_top.sv
module cyc_irq_timer_tb_top;
   import cyc_irq_pkg::*;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cyc_en = 1'b0;
   logic       wr_lo = 1'b0;
   logic       wr_hi = 1'b0;
   logic [7:0] wr_data = 8'h00;
   logic       mode_en = 1'b0;
   logic       irq_m;
   logic       irq_a;

   int total = 0;
   int bad   = 0;
   int cycles = 0;

   always #5 clk = ~clk;

   cyc_irq_timer dut_i (
      .clk(clk), .rst_n(rst_n), .cyc_en(cyc_en), .wr_lo(wr_lo), .wr_hi(wr_hi),
      .wr_data(wr_data), .mode_en(mode_en), .irq(irq_m));

   cyc_irq_timer #(.STYLE(ARM_ALWAYS)) dut_v (
      .clk(clk), .rst_n(rst_n), .cyc_en(cyc_en), .wr_lo(wr_lo), .wr_hi(wr_hi),
      .wr_data(wr_data), .mode_en(mode_en), .irq(irq_a));

   task automatic check(input string req, input string what, input logic act, input logic exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s %s: actual=%b expected=%b", req, what, act, exp);
      end
   endtask

   task automatic run(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic load(input logic [7:0] lo, input logic [7:0] hi, input logic m);
      @(negedge clk);
      cyc_en = 1'b0; mode_en = m; wr_lo = 1'b1; wr_data = lo;
      @(negedge clk);
      wr_lo = 1'b0; wr_hi = 1'b1; wr_data = hi;
      @(negedge clk);
      wr_hi = 1'b0;
   endtask

   task automatic t_reset;
      check("R6", "irq in reset (mode style)", irq_m, 1'b0);
      check("R6", "irq in reset (always style)", irq_a, 1'b0);
      @(negedge clk); rst_n = 1'b1; cyc_en = 1'b1; mode_en = 1'b1;
      run(20);
      check("R6", "no irq from disarmed counter after reset", irq_m, 1'b0);
      check("R6", "always style stays quiet after reset", irq_a, 1'b0);
      cyc_en = 1'b0;
   endtask

   task automatic t_basic;
      load(8'd5, 8'd0, 1'b1);
      cyc_en = 1'b1;
      run(4);
      check("R3", "irq low one cycle before expiry", irq_m, 1'b0);
      run(1);
      check("R4", "irq at expiry after 5 steps", irq_m, 1'b1);
      check("R9", "always style fires with enable high", irq_a, 1'b1);
      run(3);
      check("R5", "irq held as level", irq_m, 1'b1);
      cyc_en = 1'b0;
   endtask

   task automatic t_mode_off;
      load(8'd4, 8'd0, 1'b0);
      check("R1", "low write acknowledged irq", irq_m, 1'b0);
      cyc_en = 1'b1;
      run(10);
      check("R2", "mode bit low leaves counter disarmed", irq_m, 1'b0);
      check("R9", "enable low suppresses irq at expiry", irq_a, 1'b0);
      cyc_en = 1'b0;
   endtask

   task automatic t_gating;
      load(8'd3, 8'd0, 1'b1);
      cyc_en = 1'b1; @(negedge clk);
      cyc_en = 1'b0; @(negedge clk);
      cyc_en = 1'b1; @(negedge clk);
      cyc_en = 1'b0; @(negedge clk); @(negedge clk);
      check("R3", "no step while cyc_en low", irq_m, 1'b0);
      cyc_en = 1'b1; @(negedge clk);
      cyc_en = 1'b0;
      check("R3", "third enabled cycle expires", irq_m, 1'b1);
   endtask

   task automatic t_priority;
      load(8'd4, 8'd0, 1'b1);
      cyc_en = 1'b1;
      run(2);
      wr_lo = 1'b1; wr_data = 8'd5;
      @(negedge clk);
      wr_lo = 1'b0;
      run(4);
      check("R8", "write beat the step, no early expiry", irq_m, 1'b0);
      run(1);
      check("R8", "expiry exactly 5 steps after rewrite", irq_m, 1'b1);
      cyc_en = 1'b0;
   endtask

   task automatic t_one_shot;
      load(8'd3, 8'd0, 1'b1);
      cyc_en = 1'b1;
      run(3);
      check("R4", "mode style expiry", irq_m, 1'b1);
      check("R9", "always style expiry", irq_a, 1'b1);
      cyc_en = 1'b0;
      wr_lo = 1'b1; wr_data = 8'h02;
      @(negedge clk);
      wr_lo = 1'b0;
      check("R1", "ack clears irq", irq_m, 1'b0);
      cyc_en = 1'b1;
      run(16'hFF02 - 1);
      check("R9", "always style not yet refired", irq_a, 1'b0);
      run(1);
      check("R9", "always style keeps running and refires", irq_a, 1'b1);
      check("R4", "mode style disarmed after expiry", irq_m, 1'b0);
      cyc_en = 1'b0;
   endtask

   task automatic t_zero;
      load(8'd0, 8'd0, 1'b1);
      cyc_en = 1'b1;
      run(65535);
      check("R7", "zero count not expired after 65535", irq_m, 1'b0);
      run(1);
      check("R7", "zero count expires after 65536", irq_m, 1'b1);
      cyc_en = 1'b0;
   endtask

   initial begin
      run(3);
      t_reset;
      t_basic;
      t_mode_off;
      t_gating;
      t_priority;
      t_one_shot;
      t_zero;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      forever begin
         @(posedge clk);
         cycles++;
         if (cycles > 190000) begin
            total++;
            bad++;
            $display("FAIL R3 watchdog: actual=%0d cycles expected<=%0d", cycles, 190000);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
         end
      end
   end
endmodule